// File: doc/BRIEF.md
# Buffered Serial Transmitter with Clear-to-Send Gating

This block sends bytes on a single serial line as 8N1 frames. Bytes enter through a one-cycle write strobe into a 64-entry first-in first-out buffer. The block drains that buffer one frame at a time. Each bit lasts 14 ticks of a divided clock, and one tick occurs every `rate_div + 1` clock cycles. The current buffer fill count is always visible. A refill request stays high while the fill count is at or below a threshold chosen from four codes, so a host can top the buffer up in bursts.

Two controls can hold the line. A break input forces the line low while it is held, and no new frame starts during that time. An optional clear-to-send input, with selectable polarity, decides whether the next frame may begin. A frame that has already begun always runs to its end.

Top module: `hs_serial_tx`

## Requirements
- R1: After reset `txd` is high, `tx_level` is 0 and `tx_req` is high.
- R2: A cycle with `wr_en` high and fewer than 64 entries stored appends `wr_data` to the buffer. `tx_level` shows the stored count, zero-extended to 8 bits, from the clock edge that takes the write.
- R3: A write while 64 entries are stored is dropped. The count stays 64 and the stored bytes are unchanged.
- R4: `tx_req` is high exactly when `tx_level` is less than or equal to the threshold. `thr_sel` encodes the threshold as 0 = 0, 1 = 4, 2 = 8 and 3 = 16 entries.
- R5: The line idles high. A frame is a low start bit, then 8 data bits with the least significant bit first, then a high stop bit. Each bit lasts 14 ticks, and a tick is `rate_div + 1` clock cycles.
- R6: Bytes leave in the order they were written. While the buffer holds data and sending is allowed, the next frame follows the previous stop bit with no idle gap.
- R7: With `cts_en` high, a frame may start only while `cts_in` differs from `cts_inv`. A frame already in progress finishes even if this condition drops.
- R8: With `cts_en` low, `cts_in` and `cts_inv` have no effect on sending.
- R9: While `brk_force` is high, `txd` is low from the next clock edge onward and no new frame starts. When `brk_force` is released, `txd` goes back to the normal idle or frame level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_data | input | 8 | Byte to append to the buffer |
| thr_sel | input | 2 | Refill threshold code |
| rate_div | input | 8 | Clock cycles per tick, minus one |
| brk_force | input | 1 | Hold the line low |
| cts_en | input | 1 | Enable clear-to-send gating |
| cts_inv | input | 1 | Clear-to-send polarity select |
| cts_in | input | 1 | Clear-to-send input |
| txd | output | 1 | Serial line output |
| tx_level | output | 8 | Buffer fill count |
| tx_req | output | 1 | Refill request |

## Verification
The assertions assume that the control inputs (`rate_div`, `thr_sel` and the gating controls) are driven synchronously and are not X after reset. They also assume that `rate_div` stays fixed while a frame is on the line. The stimulus meets both conditions: it changes the rate only when the line is idle and the buffer is empty, and it changes every input on the falling clock edge. Random byte values and random threshold codes are applied only while clear-to-send is blocking. This keeps the fill count exact and makes the expected refill request a pure function of the pushes made.

// File: rtl/hs_serial_tx.sv
module hs_serial_tx #(
  parameter int DEPTH = 64,
  parameter int OSR   = 14,
  parameter int DIV_W = 8,
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic [1:0]       thr_sel,
  input  logic [DIV_W-1:0] rate_div,
  input  logic             brk_force,
  input  logic             cts_en,
  input  logic             cts_inv,
  input  logic             cts_in,
  output logic             txd,
  output logic [LVL_W-1:0] tx_level,
  output logic             tx_req
);

  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = AW + 1;
  localparam int SW    = $clog2(OSR);
  localparam int FRAME = 10;
  localparam int BW    = $clog2(FRAME);

  logic [7:0]       mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt;
  logic [CW-1:0]    thr_val;
  logic [DIV_W-1:0] pcnt;
  logic [SW-1:0]    sub;
  logic [BW-1:0]    bidx;
  logic [FRAME-1:0] shreg;
  logic             busy;

  wire full    = (cnt == CW'(DEPTH));
  wire push_ok = wr_en && !full;
  wire tick    = (pcnt >= rate_div);
  wire cts_ok  = !cts_en || (cts_in != cts_inv);
  wire can_go  = (cnt != '0) && cts_ok && !brk_force;
  wire last    = busy && (sub == SW'(OSR - 1)) && (bidx == BW'(FRAME - 1));
  wire pop     = tick && (!busy || last) && can_go;

  always_comb begin
    case (thr_sel)
      2'd0:    thr_val = CW'(0);
      2'd1:    thr_val = CW'(4);
      2'd2:    thr_val = CW'(8);
      default: thr_val = CW'(16);
    endcase
  end

  assign tx_req   = (cnt <= thr_val);
  assign tx_level = {{(LVL_W - CW){1'b0}}, cnt};

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop)     rptr <= rptr + 1'b1;
      cnt <= cnt + CW'(push_ok) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt <= '0;
    else        pcnt <= tick ? '0 : pcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      sub   <= '0;
      bidx  <= '0;
      shreg <= '1;
    end else if (tick) begin
      if (!busy || last) begin
        if (can_go) begin
          busy  <= 1'b1;
          shreg <= {1'b1, mem[rptr], 1'b0};
          sub   <= '0;
          bidx  <= '0;
        end else begin
          busy <= 1'b0;
        end
      end else if (sub == SW'(OSR - 1)) begin
        sub   <= '0;
        bidx  <= bidx + 1'b1;
        shreg <= {1'b1, shreg[FRAME-1:1]};
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txd <= 1'b1;
    else        txd <= brk_force ? 1'b0 : (busy ? shreg[0] : 1'b1);
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R2
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !pop) |=> (cnt == CW'(DEPTH)) && $stable(wptr)); // R3
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !brk_force) |=> txd); // R5
  AST_CTS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cts_en && (cts_in == cts_inv)) |=> !busy); // R7
  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    brk_force |=> !txd); // R9
  AST_BREAK_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && brk_force) |=> !busy); // R9

endmodule

// File: tb/hs_serial_tx_tb.sv
module hs_serial_tx_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] thr_sel = '0;
  logic [7:0] rate_div = 8'd1;
  logic       brk_force = 1'b0;
  logic       cts_en = 1'b1;
  logic       cts_inv = 1'b0;
  logic       cts_in = 1'b0;
  logic       txd;
  logic [7:0] tx_level;
  logic       tx_req;

  int total = 0;
  int bad = 0;
  int rx_count = 0;
  int model_cnt = 0;
  int cycles = 0;
  bit mon_on = 1'b1;
  logic [7:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_serial_tx dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .thr_sel(thr_sel), .rate_div(rate_div), .brk_force(brk_force),
    .cts_en(cts_en), .cts_inv(cts_inv), .cts_in(cts_in),
    .txd(txd), .tx_level(tx_level), .tx_req(tx_req)
  );

  function automatic int thr_of(input logic [1:0] c);
    case (c)
      2'd0: return 0;
      2'd1: return 4;
      2'd2: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic logic exp_req(input int lvl, input logic [1:0] c);
    return lvl <= thr_of(c);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (model_cnt < 64) begin
      model_cnt++;
      expq.push_back(d);
    end
  endtask

  task automatic wait_rx(input int n, input string tag);
    for (int i = 0; i < 60000 && rx_count < n; i++) @(negedge clk);
    chk(rx_count >= n, tag, rx_count, n);
  endtask

  // Bench receiver: decodes frames at bit centres (R5, R6)
  initial begin
    logic prev;
    logic [7:0] d;
    int bitc;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (mon_on && prev && !txd) begin
        bitc = 14 * (int'(rate_div) + 1);
        repeat (bitc / 2) @(negedge clk);
        chk(txd == 1'b0, "R5 start bit low", txd, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (bitc) @(negedge clk);
          d[i] = txd;
        end
        repeat (bitc) @(negedge clk);
        chk(txd == 1'b1, "R5 stop bit high", txd, 1);
        if (expq.size() == 0) begin
          chk(1'b0, "R6 unexpected frame", d, -1);
        end else begin
          logic [7:0] e;
          e = expq.pop_front();
          chk(d == e, "R6 byte order/data", d, e);
        end
        rx_count++;
        prev = 1'b1;
      end else begin
        prev = txd;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 190000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R1 reset txd", txd, 1);
    chk(tx_level == 0, "R1 reset level", tx_level, 0);
    chk(tx_req == 1'b1, "R1 reset req", tx_req, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Gated fill with random data and threshold codes (R2, R4, R7)
    for (int i = 0; i < 64; i++) begin
      push(8'($urandom));
      thr_sel = 2'($urandom);
      #1;
      chk(tx_level == 8'(model_cnt), "R2 level after write", tx_level, model_cnt);
      chk(tx_req == exp_req(model_cnt, thr_sel), "R4 refill request", tx_req, exp_req(model_cnt, thr_sel));
    end
    for (int c = 0; c < 4; c++) begin
      thr_sel = 2'(c);
      #1;
      chk(tx_req == 1'b0, "R4 request low when full", tx_req, 0);
    end
    // Writes to a full buffer are dropped (R3)
    for (int i = 0; i < 3; i++) begin
      push(8'hA5 ^ 8'(i));
      chk(tx_level == 8'd64, "R3 full write dropped", tx_level, 64);
    end
    // Blocked: no frame starts (R7)
    repeat (600) @(negedge clk);
    chk(txd == 1'b1, "R7 blocked line idle", txd, 1);
    chk(rx_count == 0, "R7 blocked no frame", rx_count, 0);
    chk(tx_level == 8'd64, "R7 blocked level held", tx_level, 64);

    // Allow via inverted polarity: cts_inv=1, cts_in=0 (R7, R6, R3)
    cts_inv = 1'b1;
    wait_rx(64, "R6 all 64 frames back to back");
    model_cnt = 0;
    repeat (20) @(negedge clk);
    chk(tx_level == 0, "R2 drained level", tx_level, 0);
    chk(expq.size() == 0, "R3 only first 64 sent", expq.size(), 0);

    // Mid-frame deassert: the frame completes, the next does not start (R7)
    cts_inv = 1'b0;
    cts_in = 1'b0;
    push(8'h3C);
    push(8'hC3);
    base = rx_count;
    cts_in = 1'b1;
    wait (txd == 1'b0);
    @(negedge clk);
    cts_in = 1'b0;
    wait_rx(base + 1, "R7 in-flight frame completes");
    repeat (900) @(negedge clk);
    chk(rx_count == base + 1, "R7 no start after deassert", rx_count, base + 1);
    chk(tx_level == 8'd1, "R7 one byte left", tx_level, 1);
    cts_in = 1'b1;
    wait_rx(base + 2, "R7 resumes on assert");
    model_cnt = 0;

    // CTS ignored when disabled (R8)
    cts_en = 1'b0;
    cts_in = 1'b0;
    cts_inv = 1'b0;
    base = rx_count;
    push(8'h81);
    push(8'h7E);
    wait_rx(base + 2, "R8 send with cts_in ignored");
    model_cnt = 0;

    // Different rate (R5)
    repeat (50) @(negedge clk);
    rate_div = 8'd3;
    base = rx_count;
    push(8'h01);
    push(8'hFE);
    wait_rx(base + 2, "R5 frames at rate_div=3");
    model_cnt = 0;
    repeat (50) @(negedge clk);
    rate_div = 8'd0;

    // Break: line low, frames held (R9)
    mon_on = 1'b0;
    @(negedge clk);
    brk_force = 1'b1;
    @(negedge clk);
    chk(txd == 1'b0, "R9 break low next cycle", txd, 0);
    base = rx_count;
    push(8'h55);
    push(8'hAA);
    repeat (500) @(negedge clk);
    chk(txd == 1'b0, "R9 break held low", txd, 0);
    chk(tx_level == 8'd2, "R9 no frame during break", tx_level, 2);
    brk_force = 1'b1;
    cts_en = 1'b1;
    cts_in = 1'b0;
    @(negedge clk);
    brk_force = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R9 released to idle", txd, 1);
    mon_on = 1'b1;
    @(negedge clk);
    cts_in = 1'b1;
    wait_rx(base + 2, "R9 frames after break");

    repeat (20) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule